// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block steps one switchable logic domain through power-down and power-up. A sleep request comes with an estimate of how long the domain will stay idle. The block gates the domain only when that estimate reaches a programmable break-even threshold. Otherwise the request is dropped and the domain stays powered.

On power-down it does three things in order: it clamps the domain outputs with isolation, it optionally pulses a retention-save strobe, and it then opens every power switch. On a wake request it closes the switch segments one stage at a time, which limits inrush current. It then waits a settling interval, pulses a restore strobe if state was saved, releases isolation, and finally raises the ready flag. The stage spacing and the settling interval are programmable cycle counts. A count of zero behaves as one.

A wake request that arrives while power-down is still in progress is remembered. The full power-up sequence then runs once power-down completes.

Top module: `pwr_gate_seq`

## Requirements
- R1: Out of reset every switch stage is on, isolation is off, both strobes are low and ready is high.
- R2: A sleep request while ready, with the idle estimate greater than or equal to the break-even value, raises isolation and drops ready on the next cycle.
- R3: A sleep request while ready, with the idle estimate below the break-even value, changes no output.
- R4: Isolation is high in every cycle in which any switch stage is off.
- R5: When retention is enabled at acceptance, a one-cycle save strobe follows the isolation cycle, with all switches still on. The switches open on the cycle after the save strobe, or on the cycle after the isolation cycle when retention is disabled.
- R6: On wake, switch stage 0 turns on first. The stages then turn on one per step, in thermometer order toward the top bit (vector 0001, 0011, 0111, 1111 for four stages), and each step is max(stage_gap_i,1) cycles apart.
- R7: After the last stage turns on, the block holds max(stage_gap_i,1)+max(settle_i,1) cycles before the next output change.
- R8: If state was saved, a one-cycle restore strobe follows settling while isolation is still high and all switches are on.
- R9: Isolation drops one cycle before ready rises. Ready is high only with all switches on and isolation off.
- R10: A wake request during isolation or save is held. Power-down completes, then power-up starts on the next cycle with stage 0.
- R11: A wake request while ready has no effect, and a sleep request during power-up has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_req_i | input | 1 | Request to power the domain down |
| idle_est_i | input | IDLE_W | Predicted idle duration |
| break_even_i | input | IDLE_W | Minimum idle duration worth gating |
| ret_en_i | input | 1 | Save state before power-down |
| wake_req_i | input | 1 | Request to power the domain up |
| stage_gap_i | input | CNT_W | Cycles between switch stages |
| settle_i | input | CNT_W | Settling cycles after full switch-on |
| iso_en_o | output | 1 | Clamp domain outputs |
| save_o | output | 1 | Retention save strobe |
| restore_o | output | 1 | Retention restore strobe |
| sw_en_o | output | N_STAGES | Staged power-switch enables |
| ready_o | output | 1 | Domain powered and usable |

## Verification
The assertions assume the following about the inputs. Request pulses are synchronous to the clock. The threshold, the retention enable, the stage gap and the settle count stay stable for the length of each sequence. The bench changes those inputs only between full sequences, while the domain is ready or fully off. It drives requests for a single cycle on the falling clock edge. A sleep pulse during power-up and a wake pulse during isolation are the only requests it sends outside the ready or off states.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef enum logic [2:0] {
    ST_ON, ST_ISO, ST_SAVE, ST_OFF, ST_RAMP, ST_SETTLE, ST_RESTORE, ST_DEISO
  } pgs_state_e;
endpackage

// File: rtl/pgs_timer.sv
module pgs_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_eff;

  // zero count behaves as one so every interval lasts at least a cycle
  assign load_eff  = (load_val_i == '0) ? ONE : load_val_i;
  assign expired_o = (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= ONE;
    else if (load_i)      cnt_q <= load_eff;
    else if (cnt_q > ONE) cnt_q <= cnt_q - ONE;
  end

  a_r7_count_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q != '0));
endmodule

// File: rtl/pgs_switch_chain.sv
module pgs_switch_chain #(
  parameter int N_STAGES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                start_i,
  input  logic                step_i,
  output logic [N_STAGES-1:0] sw_o,
  output logic                all_on_o
);
  logic [N_STAGES-1:0] sw_q;

  for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
    logic nxt;
    if (i == 0) begin : g_first
      always_comb begin
        if (clear_i)               nxt = 1'b0;
        else if (start_i || step_i) nxt = 1'b1;
        else                       nxt = sw_q[0];
      end
    end else begin : g_rest
      always_comb begin
        if (clear_i || start_i) nxt = 1'b0;
        else if (step_i)        nxt = sw_q[i-1];
        else                    nxt = sw_q[i];
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sw_q[i] <= 1'b1;
      else         sw_q[i] <= nxt;
    end
  end

  assign sw_o     = sw_q;
  assign all_on_o = &sw_q;

  a_r6_single_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($countones(sw_q) <= $countones($past(sw_q)) + 1));
  a_r6_thermometer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sw_q & (sw_q + 1'b1)) == '0));
endmodule

// File: rtl/pgs_gate_decide.sv
module pgs_gate_decide #(
  parameter int IDLE_W = 16
) (
  input  logic [IDLE_W-1:0] idle_est_i,
  input  logic [IDLE_W-1:0] break_even_i,
  output logic              gate_ok_o
);
  assign gate_ok_o = (idle_est_i >= break_even_i);
endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq
  import pgs_pkg::*;
#(
  parameter int N_STAGES = 4,
  parameter int CNT_W    = 8,
  parameter int IDLE_W   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sleep_req_i,
  input  logic [IDLE_W-1:0]   idle_est_i,
  input  logic [IDLE_W-1:0]   break_even_i,
  input  logic                ret_en_i,
  input  logic                wake_req_i,
  input  logic [CNT_W-1:0]    stage_gap_i,
  input  logic [CNT_W-1:0]    settle_i,
  output logic                iso_en_o,
  output logic                save_o,
  output logic                restore_o,
  output logic [N_STAGES-1:0] sw_en_o,
  output logic                ready_o
);
  pgs_state_e state_q, state_d;
  logic ret_q, ret_d, wake_pend_q, wake_pend_d;
  logic gate_ok, tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_val;
  logic sw_clear, sw_start, sw_step, sw_all_on;

  pgs_gate_decide #(.IDLE_W(IDLE_W)) i_decide (
    .idle_est_i  (idle_est_i),
    .break_even_i(break_even_i),
    .gate_ok_o   (gate_ok)
  );

  pgs_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .expired_o (tmr_exp)
  );

  pgs_switch_chain #(.N_STAGES(N_STAGES)) i_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (sw_clear),
    .start_i (sw_start),
    .step_i  (sw_step),
    .sw_o    (sw_en_o),
    .all_on_o(sw_all_on)
  );

  always_comb begin
    state_d     = state_q;
    ret_d       = ret_q;
    wake_pend_d = wake_pend_q;
    tmr_load    = 1'b0;
    tmr_val     = stage_gap_i;
    sw_clear    = 1'b0;
    sw_start    = 1'b0;
    sw_step     = 1'b0;
    unique case (state_q)
      ST_ON: if (sleep_req_i && gate_ok) begin
        state_d     = ST_ISO;
        ret_d       = ret_en_i;
        wake_pend_d = 1'b0;
      end
      ST_ISO: begin
        wake_pend_d = wake_pend_q | wake_req_i;
        if (ret_q) state_d = ST_SAVE;
        else begin
          state_d  = ST_OFF;
          sw_clear = 1'b1;
        end
      end
      ST_SAVE: begin
        wake_pend_d = wake_pend_q | wake_req_i;
        state_d     = ST_OFF;
        sw_clear    = 1'b1;
      end
      ST_OFF: if (wake_req_i || wake_pend_q) begin
        state_d     = ST_RAMP;
        wake_pend_d = 1'b0;
        sw_start    = 1'b1;
        tmr_load    = 1'b1;
      end
      ST_RAMP: if (tmr_exp) begin
        tmr_load = 1'b1;
        if (sw_all_on) begin
          state_d = ST_SETTLE;
          tmr_val = settle_i;
        end else begin
          sw_step = 1'b1;
        end
      end
      ST_SETTLE:  if (tmr_exp) state_d = ret_q ? ST_RESTORE : ST_DEISO;
      ST_RESTORE: state_d = ST_DEISO;
      ST_DEISO:   state_d = ST_ON;
      default:    state_d = ST_ON;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_ON;
      ret_q       <= 1'b0;
      wake_pend_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      ret_q       <= ret_d;
      wake_pend_q <= wake_pend_d;
    end
  end

  assign iso_en_o  = (state_q != ST_ON) && (state_q != ST_DEISO);
  assign save_o    = (state_q == ST_SAVE);
  assign restore_o = (state_q == ST_RESTORE);
  assign ready_o   = (state_q == ST_ON);

  a_r4_iso_covers_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&sw_en_o) |-> iso_en_o);
  a_r9_ready_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> ((&sw_en_o) && !iso_en_o));
  a_r9_deiso_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(!iso_en_o && (&sw_en_o)));
  a_r5_save_powered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_o |-> (iso_en_o && (&sw_en_o)));
  a_r5_open_after_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_o |=> (sw_en_o == '0));
  a_r8_restore_clamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |-> (iso_en_o && (&sw_en_o)));
  a_r2_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && sleep_req_i && (idle_est_i >= break_even_i)) |=> (iso_en_o && !ready_o));
  a_r3_short_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && sleep_req_i && (idle_est_i < break_even_i)) |=> ready_o);
  a_r11_wake_when_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !sleep_req_i) |=> ready_o);
  a_r10_wake_from_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && state_d == ST_RAMP) |=> (sw_en_o == N_STAGES'(1)));
endmodule

// File: tb/test_pwr_gate_seq.sv
module test_pwr_gate_seq;
  localparam int N = 4, CW = 8, IW = 16;
  localparam logic [N-1:0] ALL = '1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sleep_req = 1'b0, ret_en = 1'b0, wake_req = 1'b0;
  logic [IW-1:0] idle_est = '0, break_even = '0;
  logic [CW-1:0] stage_gap = '0, settle = '0;
  logic iso, save, restore, ready;
  logic [N-1:0] sw;

  always #4 clk = ~clk;

  pwr_gate_seq #(.N_STAGES(N), .CNT_W(CW), .IDLE_W(IW)) i_pwr_gate_seq (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_req_i(sleep_req), .idle_est_i(idle_est),
    .break_even_i(break_even), .ret_en_i(ret_en), .wake_req_i(wake_req),
    .stage_gap_i(stage_gap), .settle_i(settle), .iso_en_o(iso), .save_o(save),
    .restore_o(restore), .sw_en_o(sw), .ready_o(ready)
  );

  typedef struct {
    logic [N+3:0] vec;
    int           gap;
    string        tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0, cyc = 0, ref_cyc = 0;
  bit mon_on = 1'b0;
  logic [N+3:0] prev, cur;

  function automatic logic [N+3:0] mk(logic i, logic s, logic r, logic rd, logic [N-1:0] w);
    return {i, s, r, rd, w};
  endfunction

  task automatic expect_item(logic i, logic s, logic r, logic rd, logic [N-1:0] w,
                             int gap, string tag);
    item_t it;
    it.vec = mk(i, s, r, rd, w);
    it.gap = gap;
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: every output change is popped and compared with its gap
  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      cur = {iso, save, restore, ready, sw};
      if (cur !== prev) begin
        int gap;
        gap     = cyc - ref_cyc;
        ref_cyc = cyc;
        prev    = cur;
        n_chk++;
        if (q.size() == 0) begin
          n_fail++;
          $display("FAIL R11 unexpected change: actual %b expected no change", cur);
        end else begin
          item_t it;
          it = q.pop_front();
          if (cur !== it.vec || gap != it.gap) begin
            n_fail++;
            $display("FAIL %s: actual %b gap %0d expected %b gap %0d",
                     it.tag, cur, gap, it.vec, it.gap);
          end
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic check(bit ok, string tag, logic [N+3:0] act, logic [N+3:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic sleep_pulse(int idle, int be, bit ret, bit mark);
    step();
    if (mark) ref_cyc = cyc;
    idle_est   = IW'(idle);
    break_even = IW'(be);
    ret_en     = ret;
    sleep_req  = 1'b1;
    step();
    sleep_req  = 1'b0;
  endtask

  task automatic wake_pulse(bit mark);
    if (mark) ref_cyc = cyc;
    wake_req = 1'b1;
    step();
    wake_req = 1'b0;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while (q.size() != 0 && guard < 2000) begin
      step();
      guard++;
    end
    repeat (4) step();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    // R1 reset state
    check({iso, save, restore, ready, sw} === mk(0, 0, 0, 1, ALL), "R1 reset",
          {iso, save, restore, ready, sw}, mk(0, 0, 0, 1, ALL));
    prev   = {iso, save, restore, ready, sw};
    mon_on = 1'b1;

    // R3 idle estimate one below break-even: no change
    stage_gap = 8'd2;
    settle    = 8'd3;
    sleep_pulse(9, 10, 1'b1, 1'b1);
    repeat (10) step();
    check(ready === 1'b1 && iso === 1'b0 && sw === ALL, "R3 short idle",
          {iso, save, restore, ready, sw}, mk(0, 0, 0, 1, ALL));

    // R2 R5 R6 R7 R8 R9: equal estimate gates, retention on
    expect_item(1, 0, 0, 0, ALL, 1, "R2 isolate");
    expect_item(1, 1, 0, 0, ALL, 1, "R5 save");
    expect_item(1, 0, 0, 0, '0, 1, "R4 R5 switches open");
    sleep_pulse(10, 10, 1'b1, 1'b1);
    drain();
    expect_item(1, 0, 0, 0, 4'b0001, 1, "R6 stage0");
    expect_item(1, 0, 0, 0, 4'b0011, 2, "R6 stage1");
    expect_item(1, 0, 0, 0, 4'b0111, 2, "R6 stage2");
    expect_item(1, 0, 0, 0, 4'b1111, 2, "R6 stage3");
    expect_item(1, 0, 1, 0, ALL, 5, "R7 R8 restore after settle");
    expect_item(0, 0, 0, 0, ALL, 1, "R9 deiso");
    expect_item(0, 0, 0, 1, ALL, 1, "R9 ready");
    wake_pulse(1'b1);
    drain();

    // R11 wake while ready is ignored
    wake_pulse(1'b1);
    repeat (8) step();
    check(ready === 1'b1 && iso === 1'b0 && sw === ALL, "R11 wake while ready",
          {iso, save, restore, ready, sw}, mk(0, 0, 0, 1, ALL));

    // R10 wake during isolation, no retention, zero counts act as one
    stage_gap = 8'd0;
    settle    = 8'd0;
    expect_item(1, 0, 0, 0, ALL, 1, "R2 isolate");
    expect_item(1, 0, 0, 0, '0, 1, "R5 open without save");
    expect_item(1, 0, 0, 0, 4'b0001, 1, "R10 deferred wake");
    expect_item(1, 0, 0, 0, 4'b0011, 1, "R6 min gap");
    expect_item(1, 0, 0, 0, 4'b0111, 1, "R6 min gap");
    expect_item(1, 0, 0, 0, 4'b1111, 1, "R6 min gap");
    expect_item(0, 0, 0, 0, ALL, 2, "R7 min settle no restore");
    expect_item(0, 0, 0, 1, ALL, 1, "R9 ready");
    sleep_pulse(100, 3, 1'b0, 1'b1);
    wake_pulse(1'b0);
    drain();

    // R11 sleep during power-up is ignored
    stage_gap = 8'd3;
    settle    = 8'd2;
    expect_item(1, 0, 0, 0, ALL, 1, "R2 isolate");
    expect_item(1, 1, 0, 0, ALL, 1, "R5 save");
    expect_item(1, 0, 0, 0, '0, 1, "R5 switches open");
    sleep_pulse(50, 20, 1'b1, 1'b1);
    drain();
    expect_item(1, 0, 0, 0, 4'b0001, 1, "R6 stage0");
    expect_item(1, 0, 0, 0, 4'b0011, 3, "R11 stage1");
    expect_item(1, 0, 0, 0, 4'b0111, 3, "R11 stage2");
    expect_item(1, 0, 0, 0, 4'b1111, 3, "R6 stage3");
    expect_item(1, 0, 1, 0, ALL, 5, "R8 restore");
    expect_item(0, 0, 0, 0, ALL, 1, "R9 deiso");
    expect_item(0, 0, 0, 1, ALL, 1, "R9 ready");
    wake_pulse(1'b1);
    step();
    sleep_pulse(50, 20, 1'b1, 1'b0);
    drain();

    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R6 missing changes: actual %0d pending expected 0", q.size());
    end
    summary();
  end
endmodule